// File: doc/BRIEF.md
# Fast Ethernet Transmit Line Coder

This block converts transmit nibbles into a three-level line symbol stream at 125 Mbit/s. It runs on a 125 MHz bit clock and receives a one-in-five clock enable that marks the 25 MHz nibble rate. On each enabled edge it takes one nibble together with a frame-active flag and an error flag. It turns that nibble into a 5-bit code-group. It adds start-of-stream and end-of-stream delimiters around every frame and sends idle code-groups between frames.

Each code-group is shifted out one bit per bit clock, with no gap between symbols. Every bit is whitened with an 11-bit additive scrambler. The whitened bits are NRZI-coded, and the NRZI transitions drive a four-phase three-level encoder. The output is a 2-bit signed level: 0, +1 or -1. A mode input turns the code table off. In that mode the error flag and the nibble are sent unchanged as the 5-bit symbol. The reset input is asynchronous, and its deassertion must already be synchronous to the bit clock.

Top module: `fe_tx_symbol_pipe`

## Requirements
- R1: Reset drives `line_lvl` to 0 and the symbol stage to idle (11111); with `frm_act` low, only idle code-groups are sent.
- R2: In coded mode, a nibble in the body of a frame maps to its 4B/5B group. The groups for 0 to F are 11110 01001 10100 10101 01010 01011 01110 01111 10010 10011 10110 10111 11010 11011 11100 11101.
- R3: The first two nibbles of a frame are sent as J (11000) and then K (10001) instead of their data.
- R4: The first slot with `frm_act` low after a frame body is sent as T (01101). The next slot is sent as R (00111) whatever the inputs are. Idle follows after that.
- R5: A body nibble taken with `frm_err` high is sent as H (00100).
- R6: With `code_on` low, the symbol is {`frm_err`, `nib`[3:0]}, and the framing sequence returns to idle. A frame started after returning to coded mode therefore begins with J.
- R7: At each enabled edge, the symbol captured at the previous enabled edge is loaded. Its bits go out most significant bit first, one per clock.
- R8: The scrambler register resets to all ones. On every clock its key bit is bit 10 XOR bit 8, and it shifts left taking the key in as bit 0. Each serial bit is XORed with the key.
- R9: The NRZI stage toggles on a scrambled 1 and holds on a 0.
- R10: The level steps through 0, +1, 0, -1 on each NRZI transition and holds otherwise. The output encodings are 00 for 0, 01 for +1 and 11 for -1; 10 never appears.
- R11: The first bit of a symbol captured at enabled edge E affects `line_lvl` just after edge E+8. Each later bit is one clock behind the one before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nib_en | input | 1 | Nibble-rate enable, high one clock in five |
| code_on | input | 1 | 1: code-group table and framing; 0: raw bypass |
| frm_act | input | 1 | Frame in progress |
| frm_err | input | 1 | Transmit error for this nibble |
| nib | input | 4 | Transmit nibble |
| line_lvl | output | 2 | Signed three-level output |

## Verification
Each result lands a known number of clocks after its stimulus. A nibble taken at an enabled edge reaches the serial register at the next enabled edge and reaches the scrambled bit one clock after that. It reaches the NRZI stage one clock later and moves the output level one clock after the NRZI stage, eight clocks after capture in total. The bench drives inputs on falling edges and latches them again on the rising edge. On every falling edge it predicts the level from its own symbol and bit queues and compares it with `line_lvl`. It also recovers symbols from the level changes, using a key history delayed two clocks and an enable history delayed three. It then checks the delimiter, error and bypass sequences against those recovered symbols.

// File: rtl/fe_tx_pkg.sv
package fe_tx_pkg;
  localparam int NIB_W = 4;
  localparam int SYM_W = NIB_W + 1;

  typedef enum logic [1:0] {FR_IDLE, FR_SSD2, FR_BODY, FR_ESD2} frame_st_e;

  localparam logic [SYM_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] CG_J    = 5'b11000;
  localparam logic [SYM_W-1:0] CG_K    = 5'b10001;
  localparam logic [SYM_W-1:0] CG_T    = 5'b01101;
  localparam logic [SYM_W-1:0] CG_R    = 5'b00111;
  localparam logic [SYM_W-1:0] CG_H    = 5'b00100;

  function automatic logic [SYM_W-1:0] cg_of_nibble(input logic [NIB_W-1:0] n);
    logic [SYM_W-1:0] g;
    case (n)
      4'h0: g = 5'b11110;
      4'h1: g = 5'b01001;
      4'h2: g = 5'b10100;
      4'h3: g = 5'b10101;
      4'h4: g = 5'b01010;
      4'h5: g = 5'b01011;
      4'h6: g = 5'b01110;
      4'h7: g = 5'b01111;
      4'h8: g = 5'b10010;
      4'h9: g = 5'b10011;
      4'hA: g = 5'b10110;
      4'hB: g = 5'b10111;
      4'hC: g = 5'b11010;
      4'hD: g = 5'b11011;
      4'hE: g = 5'b11100;
      default: g = 5'b11101;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/fe_tx_coder.sv
module fe_tx_coder
  import fe_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nib_en,
  input  logic             code_on,
  input  logic             frm_act,
  input  logic             frm_err,
  input  logic [NIB_W-1:0] nib,
  output logic [SYM_W-1:0] sym
);
  frame_st_e        st_q, st_nx;
  logic [SYM_W-1:0] sym_q, sym_nx;

  always_comb begin
    st_nx  = st_q;
    sym_nx = sym_q;
    if (nib_en) begin
      if (!code_on) begin
        sym_nx = {frm_err, nib};
        st_nx  = FR_IDLE;
      end else begin
        case (st_q)
          FR_IDLE: begin
            if (frm_act) begin
              sym_nx = CG_J;
              st_nx  = FR_SSD2;
            end else begin
              sym_nx = CG_IDLE;
            end
          end
          FR_SSD2: begin
            sym_nx = CG_K;
            st_nx  = FR_BODY;
          end
          FR_BODY: begin
            if (frm_act) begin
              sym_nx = frm_err ? CG_H : cg_of_nibble(nib);
            end else begin
              sym_nx = CG_T;
              st_nx  = FR_ESD2;
            end
          end
          default: begin
            sym_nx = CG_R;
            st_nx  = FR_IDLE;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FR_IDLE;
      sym_q <= CG_IDLE;
    end else begin
      st_q  <= st_nx;
      sym_q <= sym_nx;
    end
  end

  assign sym = sym_q;
endmodule

// File: rtl/fe_tx_serscr.sv
module fe_tx_serscr
  import fe_tx_pkg::*;
#(
  parameter int                LFSR_W    = 11,
  parameter int                LFSR_TAP  = 8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nib_en,
  input  logic [SYM_W-1:0] sym,
  output logic             ser_bit,
  output logic             scr_bit
);
  localparam int MSB = SYM_W - 1;

  logic [SYM_W-1:0]  sh_q, sh_nx;
  logic [LFSR_W-1:0] lfsr_q, lfsr_nx;
  logic              scr_q, scr_nx;
  logic              key;

  always_comb begin
    key     = lfsr_q[LFSR_W-1] ^ lfsr_q[LFSR_TAP];
    lfsr_nx = {lfsr_q[LFSR_W-2:0], key};
    scr_nx  = sh_q[MSB] ^ key;
    if (nib_en) sh_nx = sym;
    else        sh_nx = {sh_q[MSB-1:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      lfsr_q <= LFSR_SEED;
      scr_q  <= 1'b0;
    end else begin
      sh_q   <= sh_nx;
      lfsr_q <= lfsr_nx;
      scr_q  <= scr_nx;
    end
  end

  assign ser_bit = sh_q[MSB];
  assign scr_bit = scr_q;
endmodule

// File: rtl/fe_tx_line.sv
module fe_tx_line (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scr_bit,
  output logic [1:0] line_lvl
);
  logic       nrzi_q, nrzi_d_q;
  logic [1:0] ph_q, ph_nx;
  logic       trans;

  always_comb begin
    trans = nrzi_q ^ nrzi_d_q;
    ph_nx = ph_q + {1'b0, trans};
    case (ph_q)
      2'd1:    line_lvl = 2'b01;
      2'd3:    line_lvl = 2'b11;
      default: line_lvl = 2'b00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrzi_q   <= 1'b0;
      nrzi_d_q <= 1'b0;
      ph_q     <= 2'd0;
    end else begin
      nrzi_q   <= nrzi_q ^ scr_bit;
      nrzi_d_q <= nrzi_q;
      ph_q     <= ph_nx;
    end
  end
endmodule

// File: rtl/fe_tx_symbol_pipe.sv
module fe_tx_symbol_pipe
  import fe_tx_pkg::*;
#(
  parameter int                LFSR_W    = 11,
  parameter int                LFSR_TAP  = 8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nib_en,
  input  logic             code_on,
  input  logic             frm_act,
  input  logic             frm_err,
  input  logic [NIB_W-1:0] nib,
  output logic [1:0]       line_lvl
);
  logic [SYM_W-1:0] sym_w;
  logic             ser_w;
  logic             scr_w;

  fe_tx_coder u_coder (
    .clk(clk), .rst_n(rst_n), .nib_en(nib_en), .code_on(code_on),
    .frm_act(frm_act), .frm_err(frm_err), .nib(nib), .sym(sym_w)
  );

  fe_tx_serscr #(.LFSR_W(LFSR_W), .LFSR_TAP(LFSR_TAP), .LFSR_SEED(LFSR_SEED)) u_serscr (
    .clk(clk), .rst_n(rst_n), .nib_en(nib_en), .sym(sym_w),
    .ser_bit(ser_w), .scr_bit(scr_w)
  );

  fe_tx_line u_line (
    .clk(clk), .rst_n(rst_n), .scr_bit(scr_w), .line_lvl(line_lvl)
  );
endmodule

// File: rtl/fe_tx_chk.sv
module fe_tx_chk
  import fe_tx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             nib_en,
  input logic             code_on,
  input logic             frm_err,
  input logic [NIB_W-1:0] nib,
  input logic [SYM_W-1:0] sym,
  input logic             ser_bit,
  input logic [1:0]       line_lvl
);
  logic [SYM_W-1:0] prev_sym;
  logic             enc_cur, enc_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sym <= '0;
      enc_cur  <= 1'b0;
      enc_prev <= 1'b0;
    end else if (nib_en) begin
      prev_sym <= sym;
      enc_prev <= enc_cur;
      enc_cur  <= code_on;
    end
  end

  AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) line_lvl != 2'b10); // R10
  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n) (line_lvl != $past(line_lvl)) |-> (line_lvl == 2'b00 || $past(line_lvl) == 2'b00)); // R10
  AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (!rst_n) (nib_en && !code_on) |=> (sym == $past({frm_err, nib}))); // R6
  AST_SER_LOAD: assert property (@(posedge clk) disable iff (!rst_n) nib_en |=> (ser_bit == $past(sym[SYM_W-1]))); // R7
  AST_K_AFTER_J: assert property (@(posedge clk) disable iff (!rst_n) (nib_en && enc_prev && enc_cur && prev_sym == CG_J) |-> (sym == CG_K)); // R3
  AST_R_AFTER_T: assert property (@(posedge clk) disable iff (!rst_n) (nib_en && enc_prev && enc_cur && prev_sym == CG_T) |-> (sym == CG_R)); // R4
endmodule

bind fe_tx_symbol_pipe fe_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nib_en(nib_en), .code_on(code_on),
  .frm_err(frm_err), .nib(nib), .sym(sym_w), .ser_bit(ser_w), .line_lvl(line_lvl)
);

// File: tb/tb_fe_tx_symbol_pipe.sv
module tb_fe_tx_symbol_pipe;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nib_en = 1'b0;
  logic       code_on = 1'b1;
  logic       frm_act = 1'b0;
  logic       frm_err = 1'b0;
  logic [3:0] nib = 4'h0;
  logic [1:0] line_lvl;

  fe_tx_symbol_pipe dut (
    .clk(clk), .rst_n(rst_n), .nib_en(nib_en), .code_on(code_on),
    .frm_act(frm_act), .frm_err(frm_err), .nib(nib), .line_lvl(line_lvl)
  );

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int ph = 4;
  always @(negedge clk) begin
    ph = (ph == 4) ? 0 : ph + 1;
    nib_en = (ph == 0);
  end

  // inputs as seen at the latest rising edge
  bit e_live, e_nib, e_en, e_er, e_code;
  bit [3:0] e_d;
  always @(posedge clk) begin
    e_live = rst_n; e_nib = nib_en; e_en = frm_act;
    e_er = frm_err; e_code = code_on; e_d = nib;
  end

  localparam bit [4:0] I_ = 5'b11111, J_ = 5'b11000, K_ = 5'b10001;
  localparam bit [4:0] T_ = 5'b01101, R_ = 5'b00111, H_ = 5'b00100;
  bit [4:0] tbl [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
                         5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
                         5'b11010, 5'b11011, 5'b11100, 5'b11101};

  int fst;  // 0 idle, 1 second delimiter, 2 body, 3 closing R
  function automatic bit [4:0] frame_sym(input bit c, input bit en, input bit er, input bit [3:0] d);
    bit [4:0] s;
    if (!c) begin s = {er, d}; fst = 0; end
    else if (fst == 0) begin s = en ? J_ : I_; if (en) fst = 1; end
    else if (fst == 1) begin s = K_; fst = 2; end
    else if (fst == 2) begin s = en ? (er ? H_ : tbl[d]) : T_; if (!en) fst = 3; end
    else begin s = R_; fst = 0; end
    return s;
  endfunction

  int lf, s1, s2, pprev, mph, prev_line, racc, rcnt;
  int kh [3];
  int nh [4];
  bit [4:0] symq [$];
  bit       bitq [$];
  bit [4:0] recq [$];

  always @(negedge clk) begin
    if (!e_live) begin
      lf = 'h7FF; s1 = 0; s2 = 0; pprev = 0; mph = 0; fst = 0; prev_line = 0;
      racc = 0; rcnt = 0; kh = '{0, 0, 0}; nh = '{0, 0, 0, 0};
      symq.delete(); symq.push_back(I_); bitq.delete();
    end else begin
      int k, adv, p, expv, act, srec, prec;
      bit [4:0] cur;
      k = ((lf >> 10) ^ (lf >> 8)) & 1;
      lf = ((lf << 1) | k) & 'h7FF;
      adv = s2; s2 = s1; s1 = pprev ^ k;
      if (adv != 0) mph = (mph + 1) % 4;
      if (e_nib) begin
        cur = symq.pop_front();
        for (int i = 4; i >= 0; i--) bitq.push_back(cur[i]);
        symq.push_back(frame_sym(e_code, e_en, e_er, e_d));
      end
      p = (bitq.size() > 0) ? int'(bitq.pop_front()) : 0;
      pprev = p;
      expv = (mph == 1) ? 1 : (mph == 3) ? -1 : 0;
      act = $signed(line_lvl);
      chk(act == expv, "R8 R9 R10 R11 line level", act, expv);
      // recover the plain bit sent three clocks ago
      kh[2] = kh[1]; kh[1] = kh[0]; kh[0] = k;
      nh[3] = nh[2]; nh[2] = nh[1]; nh[1] = nh[0]; nh[0] = e_nib;
      srec = (int'(line_lvl) != prev_line) ? 1 : 0;
      prev_line = int'(line_lvl);
      prec = srec ^ kh[2];
      if (nh[3] != 0) begin racc = prec; rcnt = 1; end
      else if (rcnt > 0) begin racc = (racc << 1) | prec; rcnt++; end
      if (rcnt == 5) begin recq.push_back(racc[4:0]); rcnt = 0; end
    end
  end

  task automatic put(input bit c, input bit en, input bit er, input bit [3:0] d);
    do @(posedge clk); while (!nib_en);
    @(negedge clk);
    code_on = c; frm_act = en; frm_err = er; nib = d;
  endtask

  task automatic flush();
    for (int i = 0; i < 8; i++) put(1'b1, 1'b0, 1'b0, 4'h0);
  endtask

  task automatic check_seq(input bit [4:0] exp [$], input string req);
    int idx = 0;
    while (idx < recq.size() && recq[idx] == I_) idx++;
    for (int i = 0; i < exp.size(); i++) begin
      int act = (idx + i < recq.size()) ? int'(recq[idx + i]) : -1;
      chk(act == int'(exp[i]), req, act, int'(exp[i]));
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    bit [4:0] q [$];
    repeat (3) @(negedge clk);
    chk(line_lvl == 2'b00, "R1 reset level", int'(line_lvl), 0);
    rst_n = 1'b1;
    repeat (60) @(negedge clk);
    // R1: only idle groups while no frame
    chk(recq.size() > 5, "R1 idle count", recq.size(), 6);
    foreach (recq[i]) chk(recq[i] == I_, "R1 idle group", int'(recq[i]), int'(I_));

    // R2 R3 R4 R7: frame carrying every nibble value
    recq.delete();
    put(1, 1, 0, 4'h5); put(1, 1, 0, 4'h5);
    for (int d = 0; d < 16; d++) put(1, 1, 0, d[3:0]);
    flush();
    q = '{J_, K_};
    for (int d = 0; d < 16; d++) q.push_back(tbl[d]);
    q.push_back(T_); q.push_back(R_); q.push_back(I_);
    check_seq(q, "R2 R3 R4 R7 frame groups");

    // R5: error nibble in the body
    recq.delete();
    put(1, 1, 0, 4'h5); put(1, 1, 1, 4'h5);
    put(1, 1, 0, 4'h3); put(1, 1, 1, 4'h7); put(1, 1, 0, 4'h9);
    flush();
    q = '{J_, K_, 5'b10101, H_, 5'b10011, T_, R_, I_};
    check_seq(q, "R5 error group");

    // R6: raw bypass, then a frame resumes with J
    recq.delete();
    put(0, 0, 1, 4'hA); put(0, 1, 0, 4'h3); put(0, 0, 1, 4'h0); put(0, 1, 0, 4'h6);
    put(1, 1, 0, 4'h5); put(1, 1, 0, 4'h5); put(1, 1, 0, 4'hC); put(1, 0, 0, 4'h0);
    flush();
    q = '{5'b11010, 5'b00011, 5'b10000, 5'b00110, J_, K_, 5'b11010, T_, R_, I_};
    check_seq(q, "R6 bypass groups");

    // R6: bypass in mid-frame drops the framing state
    recq.delete();
    put(1, 1, 0, 4'h5); put(1, 1, 0, 4'h5); put(1, 1, 0, 4'h1);
    put(0, 1, 0, 4'h2); put(1, 1, 0, 4'h4); put(1, 1, 0, 4'h4); put(1, 1, 0, 4'h8);
    flush();
    q = '{J_, K_, 5'b01001, 5'b00010, J_, K_, 5'b10010, T_, R_, I_};
    check_seq(q, "R6 framing restart");

    repeat (20) @(negedge clk);
    summary();
    $finish;
  end
endmodule